// File: doc/BRIEF.md
# PLL Divider Pair Search Engine

This block turns a requested pixel-clock frequency into PLL divider settings. The request is given in hundredths of a MHz. The engine works against a fixed 14.31818 MHz reference. It clamps the request into the PLL's working band and scales the request up to pick a post-divide exponent K. It then tries every feedback/reference divider pair (N, M) in a fixed order. Each candidate output is worked out in 8-bit fixed point through one shared shift-and-subtract divider. The engine keeps the pair whose output lies closest to the request.

A request enters through a valid/ready handshake. The engine takes a new request only while it is idle. Once the last pair has been tried, it presents one 16-bit program word through a second valid/ready handshake. The word holds K, M and N. Writing the word to the clock chip is left to the surrounding logic.

Top module: `pll_divider_search`

## Requirements
- R1: The request is clamped to at least 8000 and at most 15938. Any request below 8000 gives the same word as 8000, and any request above 15938 gives the same word as 15938.
- R2: The comparison target is floor(clamped × 256 / 100).
- R3: K starts at 0. While the working frequency is below 64000 and K is below 3, the working frequency doubles and K increments. For every clamped request this yields K = 3, which appears in word bits [7:6].
- R4: Each candidate output is floor(938356 × (N+8) / (2^K × 256 × (M+2))).
- R5: M is the outer loop, running from M_LO to M_HI. N is the inner loop, running from N_LO to N_HI. The best error starts at 0xFFFFFFFF. A candidate replaces the best pair only if its absolute error against the target is strictly smaller, so on a tie the earlier pair is kept.
- R6: The output word is (K<<6) + M + (N<<8). N sits in bits [15:8], K in bits [7:6] and M in bits [5:0].
- R7: in_ready is high only while the engine is idle. A request is taken on a clock edge where in_valid and in_ready are both high. An in_valid raised while the engine is busy has no effect on the result.
- R8: out_valid stays high and out_word stays unchanged until out_ready is seen high at a clock edge. After that edge the engine returns to idle with in_ready high.
- R9: out_valid rises exactly 4 + P × (QW + 2) clock edges after the edge that takes the request. P is the number of (M, N) pairs.
- R10: While rst_n is low, and at the first edge after it goes low, in_ready is 1 and out_valid is 0. An ongoing search is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Engine idle, request will be taken |
| in_freq | input | 16 | Requested frequency in 0.01 MHz units |
| out_valid | output | 1 | Program word present |
| out_ready | input | 1 | Consumer takes the program word |
| out_word | output | 16 | Packed program word {N, K, M} |

## Verification
Clamping and K scaling take four edges after the request edge. Each (M, N) candidate then takes one issue edge, QW divider steps and one compare edge. The result is therefore due 4 + P × (QW + 2) edges after the request edge. The bench counts edges from the request edge and samples on falling edges, so the latency check measures that exact count. The expected word comes from a behavioural model of the clamp, scale and exhaustive search, built from the requirements. A smaller M/N range keeps each search short while still letting the target fall inside and outside the reachable band.

// File: rtl/pll_search_pkg.sv
// Package: shared constants, state type and word packing for the
// PLL divider pair search engine.
// Assumes: the word layout is fixed at 8/2/6 bits for N/K/M.
package pll_search_pkg;

    localparam int unsigned FREQ_LO    = 8000;
    localparam int unsigned FREQ_HI    = 15938;
    localparam int unsigned SCALE_STOP = FREQ_LO << 3;
    localparam int unsigned K_CAP      = 3;
    localparam int unsigned REF_X65536 = 938356;
    localparam int unsigned M_W        = 6;
    localparam int unsigned N_W        = 8;
    localparam int unsigned K_W        = 2;
    localparam int unsigned REQ_W      = 16;
    localparam int unsigned WF_W       = REQ_W + 1;
    localparam int unsigned TGT_W      = 16;
    localparam int unsigned ERR_W      = 32;
    localparam int unsigned NUM_W      = 32;
    localparam int unsigned DEN_W      = 18;
    localparam int unsigned WORD_W     = N_W + K_W + M_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCALE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } srch_state_t;

    // Packs K, M, N as (K<<6) + M + (N<<8).
    function automatic logic [WORD_W-1:0] pack_word(
        input logic [K_W-1:0] k,
        input logic [M_W-1:0] m,
        input logic [N_W-1:0] n
    );
        return WORD_W'({n, {(K_W + M_W){1'b0}}})
             + WORD_W'({k, {M_W{1'b0}}})
             + WORD_W'(m);
    endfunction

endpackage

// File: rtl/pll_req_cond.sv
// Request conditioner: clamps the request into the PLL band and
// derives the 8-bit fixed-point comparison target (clamped*256/100).
// Assumes: purely combinational; the caller registers the results.
module pll_req_cond
    import pll_search_pkg::*;
(
    input  logic [REQ_W-1:0] req,
    output logic [REQ_W-1:0] clamped,
    output logic [TGT_W-1:0] target
);

    logic [31:0] scaled;

    // Clamp the request into [FREQ_LO, FREQ_HI].
    always_comb begin
        if (32'(req) < FREQ_LO)
            clamped = REQ_W'(FREQ_LO);
        else if (32'(req) > FREQ_HI)
            clamped = REQ_W'(FREQ_HI);
        else
            clamped = req;
    end

    // Scale to 8-bit fixed point of MHz.
    always_comb begin
        scaled = (32'(clamped) << 8) / 32'd100;
        target = TGT_W'(scaled);
    end

endmodule

// File: rtl/pll_shift_div.sv
// Shift-and-subtract (restoring) divider shared by all candidates.
// Takes QW steps after a start pulse and then holds done high for one cycle.
// Assumes: the true quotient fits in QW bits and den is non-zero.
module pll_shift_div #(
    parameter int unsigned NUMW = 32,
    parameter int unsigned DENW = 18,
    parameter int unsigned QW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NUMW-1:0] num,
    input  logic [DENW-1:0] den,
    output logic            done,
    output logic [QW-1:0]   quo
);

    localparam int unsigned SW  = DENW + QW - 1;
    localparam int unsigned CW  = $clog2(QW + 1);
    localparam int unsigned XW  = (SW > NUMW) ? SW : NUMW;

    logic [NUMW-1:0] rem;
    logic [SW-1:0]   sdiv;
    logic [CW-1:0]   steps;
    logic            busy;
    logic [NUMW-1:0] num_q;
    logic [DENW-1:0] den_q;
    logic            fits;

    assign fits = XW'(rem) >= XW'(sdiv);
    assign done = busy && (steps == '0);

    // Load operands on start, then one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            sdiv  <= '0;
            steps <= '0;
            busy  <= 1'b0;
            quo   <= '0;
            num_q <= '0;
            den_q <= '0;
        end else if (start) begin
            rem   <= num;
            sdiv  <= SW'(den) << (QW - 1);
            steps <= CW'(QW);
            busy  <= 1'b1;
            quo   <= '0;
            num_q <= num;
            den_q <= den;
        end else if (busy) begin
            if (steps != '0) begin
                if (fits)
                    rem <= rem - NUMW'(sdiv);
                quo   <= {quo[QW-2:0], fits};
                sdiv  <= sdiv >> 1;
                steps <= steps - 1'b1;
            end else begin
                busy <= 1'b0;
            end
        end
    end

    // R4: a finished quotient and remainder reproduce the dividend.
    p_div_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((64'(quo) * 64'(den_q) + 64'(rem) == 64'(num_q))
                  && (NUMW'(rem) < NUMW'(den_q))));

endmodule

// File: rtl/pll_pair_walk.sv
// Pair walker: steps (M, N) with M outer and N inner over the
// parameter ranges, and flags the final pair.
// Assumes: M_LO <= M_HI < 2^M_W and N_LO <= N_HI < 2^N_W.
module pll_pair_walk
    import pll_search_pkg::*;
#(
    parameter int unsigned M_LO = 2,
    parameter int unsigned M_HI = 30,
    parameter int unsigned N_LO = 35,
    parameter int unsigned N_HI = 248
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           advance,
    output logic [M_W-1:0] m,
    output logic [N_W-1:0] n,
    output logic           last
);

    assign last = (m == M_W'(M_HI)) && (n == N_W'(N_HI));

    // Restart at the first pair, or move to the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m <= M_W'(M_LO);
            n <= N_W'(N_LO);
        end else if (restart) begin
            m <= M_W'(M_LO);
            n <= N_W'(N_LO);
        end else if (advance) begin
            if (n == N_W'(N_HI)) begin
                n <= N_W'(N_LO);
                m <= m + 1'b1;
            end else begin
                n <= n + 1'b1;
            end
        end
    end

    // R5: the walk never leaves the configured ranges.
    p_pair_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m >= M_W'(M_LO)) && (m <= M_W'(M_HI))
        && (n >= N_W'(N_LO)) && (n <= N_W'(N_HI)));

endmodule

// File: rtl/pll_divider_search.sv
// PLL divider pair search engine (top). Clamps a request, scales it to
// choose K, then evaluates every (M, N) pair through a shared divider.
// It keeps the first pair with the strictly smallest error and presents
// the packed word.
// Assumes: the output of every candidate fits in QW quotient bits.
module pll_divider_search
    import pll_search_pkg::*;
#(
    parameter int unsigned M_LO = 2,
    parameter int unsigned M_HI = 30,
    parameter int unsigned N_LO = 35,
    parameter int unsigned N_HI = 248,
    parameter int unsigned QW   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [REQ_W-1:0]  in_freq,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word
);

    localparam logic [ERR_W-1:0] ERR_INIT = '1;

    srch_state_t       state;
    logic [WF_W-1:0]   work_f;
    logic [K_W-1:0]    k;
    logic [TGT_W-1:0]  target_q;
    logic [ERR_W-1:0]  best_err;
    logic [M_W-1:0]    best_m;
    logic [N_W-1:0]    best_n;
    logic [WORD_W-1:0] word_q;

    logic [REQ_W-1:0]  req_clamped;
    logic [TGT_W-1:0]  req_target;
    logic [M_W-1:0]    cur_m;
    logic [N_W-1:0]    cur_n;
    logic              pair_last;
    logic              div_done;
    logic [QW-1:0]     div_quo;
    logic [NUM_W-1:0]  cand_num;
    logic [DEN_W-1:0]  cand_den;
    logic [ERR_W-1:0]  cand_out;
    logic [ERR_W-1:0]  cand_err;
    logic              take_new;
    logic              scale_more;
    logic              scale_exit;
    logic              search_active;
    logic [M_W-1:0]    sel_m;
    logic [N_W-1:0]    sel_n;

    assign in_ready      = (state == ST_IDLE);
    assign out_valid     = (state == ST_DONE);
    assign out_word      = word_q;
    assign search_active = (state == ST_ISSUE) || (state == ST_WAIT);

    pll_req_cond i_cond (
        .req     (in_freq),
        .clamped (req_clamped),
        .target  (req_target)
    );

    // Decide whether the working frequency still needs doubling.
    always_comb begin
        scale_more = (32'(work_f) < SCALE_STOP) && (32'(k) < K_CAP);
        scale_exit = (state == ST_SCALE) && !scale_more;
    end

    pll_pair_walk #(
        .M_LO (M_LO),
        .M_HI (M_HI),
        .N_LO (N_LO),
        .N_HI (N_HI)
    ) i_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (scale_exit),
        .advance ((state == ST_WAIT) && div_done && !pair_last),
        .m       (cur_m),
        .n       (cur_n),
        .last    (pair_last)
    );

    // Candidate operands: REF*(N+8) over (M+2) << (8+K).
    always_comb begin
        cand_num = (NUM_W'(cur_n) + NUM_W'(8)) * NUM_W'(REF_X65536);
        cand_den = (DEN_W'(cur_m) + DEN_W'(2)) << (8 + 32'(k));
    end

    pll_shift_div #(
        .NUMW (NUM_W),
        .DENW (DEN_W),
        .QW   (QW)
    ) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (state == ST_ISSUE),
        .num   (cand_num),
        .den   (cand_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    // Absolute error of the finished candidate and the best-pair choice.
    always_comb begin
        cand_out = ERR_W'(div_quo);
        if (ERR_W'(target_q) > cand_out)
            cand_err = ERR_W'(target_q) - cand_out;
        else
            cand_err = cand_out - ERR_W'(target_q);
        take_new = cand_err < best_err;
        sel_m    = take_new ? cur_m : best_m;
        sel_n    = take_new ? cur_n : best_n;
    end

    // Main sequencer: accept, scale, issue/wait per pair, present result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            work_f   <= '0;
            k        <= '0;
            target_q <= '0;
            best_err <= ERR_INIT;
            best_m   <= '0;
            best_n   <= '0;
            word_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        work_f   <= WF_W'(req_clamped);
                        target_q <= req_target;
                        k        <= '0;
                        state    <= ST_SCALE;
                    end
                end
                ST_SCALE: begin
                    if (scale_more) begin
                        work_f <= work_f << 1;
                        k      <= k + 1'b1;
                    end else begin
                        best_err <= ERR_INIT;
                        state    <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (div_done) begin
                        if (take_new) begin
                            best_err <= cand_err;
                            best_m   <= cur_m;
                            best_n   <= cur_n;
                        end
                        if (pair_last) begin
                            word_q <= pack_word(k, sel_m, sel_n);
                            state  <= ST_DONE;
                        end else begin
                            state <= ST_ISSUE;
                        end
                    end
                end
                ST_DONE: begin
                    if (out_ready)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: the registered working frequency lies in the clamp band.
    p_clamp_band_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ((32'(work_f) >= FREQ_LO)
                                    && (32'(work_f) <= FREQ_HI)));

    // R3: scaling ends only at the stop level or the K cap.
    p_scale_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ISSUE) && ($past(state) == ST_SCALE))
            |-> ((32'(work_f) >= SCALE_STOP) || (32'(k) == K_CAP)));

    // R5: within one search the best error never grows.
    p_best_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (search_active && $past(search_active))
            |-> (best_err <= $past(best_err)));

    // R7: while busy the stored target cannot be overwritten.
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(target_q));

    // R8: a presented word is held until taken.
    p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

endmodule

// File: tb/test_pll_divider_search.sv
`timescale 1ns/1ps
module test_pll_divider_search;

    localparam int unsigned TB_M_LO = 2;
    localparam int unsigned TB_M_HI = 5;
    localparam int unsigned TB_N_LO = 200;
    localparam int unsigned TB_N_HI = 248;
    localparam int unsigned TB_QW   = 16;
    localparam int unsigned PAIRS   = (TB_M_HI - TB_M_LO + 1) * (TB_N_HI - TB_N_LO + 1);
    localparam int unsigned LAT     = 4 + PAIRS * (TB_QW + 2);
    localparam int unsigned NVEC    = 11;
    localparam int unsigned WD_MAX  = 150000;

    // Stimulus table: request and expected K field.
    localparam int unsigned VEC_REQ [NVEC] =
        '{0, 7999, 8000, 9000, 10000, 11500, 12000, 13500, 15938, 15939, 65535};
    localparam int unsigned VEC_K   [NVEC] =
        '{3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_freq = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_word;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    pll_divider_search #(
        .M_LO (TB_M_LO),
        .M_HI (TB_M_HI),
        .N_LO (TB_N_LO),
        .N_HI (TB_N_HI),
        .QW   (TB_QW)
    ) i_pll_divider_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_freq   (in_freq),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_word  (out_word)
    );

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_MAX) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog R9: actual %0d cycles expected below %0d", cyc, WD_MAX);
            report();
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural model of R1..R6.
    function automatic logic [15:0] ref_word(input int unsigned req);
        longint f, tgt, w, best, fo, d;
        int k, bm, bn;
        f = (req < 8000) ? 8000 : ((req > 15938) ? 15938 : req);
        tgt = (f * 256) / 100;
        w = f;
        k = 0;
        while (w < 64000 && k < 3) begin
            w = w * 2;
            k = k + 1;
        end
        best = 64'hFFFF_FFFF;
        bm = 0;
        bn = 0;
        for (int m = TB_M_LO; m <= TB_M_HI; m++) begin
            for (int n = TB_N_LO; n <= TB_N_HI; n++) begin
                fo = (longint'(938356) * (n + 8)) / ((longint'(1) << k) * 256 * (m + 2));
                d = (tgt > fo) ? tgt - fo : fo - tgt;
                if (d < best) begin
                    best = d;
                    bm = m;
                    bn = n;
                end
            end
        end
        return 16'((k << 6) + bm + (bn << 8));
    endfunction

    // One request; measures latency, optional back-pressure and busy poke.
    task automatic run_req(input int unsigned req, input bit hold_out, input bit poke,
                           output logic [15:0] word, output int lat);
        logic [15:0] w0;
        @(negedge clk);
        in_freq   = 16'(req);
        in_valid  = 1'b1;
        out_ready = !hold_out;
        @(posedge clk);
        lat = 0;
        forever begin
            @(negedge clk);
            if (poke && lat < 50) begin
                in_valid = 1'b1;
                in_freq  = 16'd15000;
                if (lat == 10)
                    chk("R7 in_ready low while busy", in_ready, 0);
            end else begin
                in_valid = 1'b0;
            end
            if (out_valid || lat > LAT + 100)
                break;
            @(posedge clk);
            lat = lat + 1;
        end
        in_valid = 1'b0;
        word = out_word;
        if (hold_out) begin
            w0 = out_word;
            repeat (5) begin
                @(negedge clk);
                chk("R8 valid held", out_valid, 1);
                chk("R8 word held", out_word, w0);
            end
            out_ready = 1'b1;
            @(negedge clk);
            chk("R8 released valid", out_valid, 0);
            chk("R8 back to idle", in_ready, 1);
        end
    endtask

    initial begin
        logic [15:0] w;
        logic [15:0] w_lo;
        logic [15:0] w_hi;
        int lat;

        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 reset in_ready", in_ready, 1);
        chk("R10 reset out_valid", out_valid, 0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R4 R5 R6 word, R3 K field, R9 latency
        for (int i = 0; i < NVEC; i++) begin
            run_req(VEC_REQ[i], 1'b0, 1'b0, w, lat);
            chk($sformatf("R5 R6 word req %0d", VEC_REQ[i]), w, ref_word(VEC_REQ[i]));
            chk($sformatf("R3 K field req %0d", VEC_REQ[i]), w[7:6], VEC_K[i]);
            chk($sformatf("R9 latency req %0d", VEC_REQ[i]), lat, LAT);
        end

        // R1: clamp equivalence at both ends
        run_req(3, 1'b0, 1'b0, w_lo, lat);
        run_req(8000, 1'b0, 1'b0, w, lat);
        chk("R1 low clamp equal", w_lo, w);
        run_req(40000, 1'b0, 1'b0, w_hi, lat);
        run_req(15938, 1'b0, 1'b0, w, lat);
        chk("R1 high clamp equal", w_hi, w);

        // R6: field positions for a mid request
        run_req(11000, 1'b0, 1'b0, w, lat);
        chk("R6 N field range", (w[15:8] >= TB_N_LO && w[15:8] <= TB_N_HI), 1);
        chk("R6 M field range", (w[5:0] >= TB_M_LO && w[5:0] <= TB_M_HI), 1);
        chk("R2 R4 mid word", w, ref_word(11000));

        // R8: back-pressure holds the word
        run_req(12345, 1'b1, 1'b0, w, lat);
        chk("R8 held result", w, ref_word(12345));

        // R7: requests while busy are ignored
        run_req(9000, 1'b0, 1'b1, w, lat);
        chk("R7 busy request ignored", w, ref_word(9000));
        chk("R7 differs from poke", (ref_word(9000) != ref_word(15000)), 1);
        @(negedge clk);
        chk("R7 idle after result", in_ready, 1);

        // R10: reset in the middle of a search
        @(negedge clk);
        in_freq  = 16'd10000;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (100) @(negedge clk);
        chk("R10 busy before reset", in_ready, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid reset in_ready", in_ready, 1);
        chk("R10 mid reset out_valid", out_valid, 0);
        rst_n = 1'b1;
        run_req(14000, 1'b0, 1'b0, w, lat);
        chk("R10 after reset word", w, ref_word(14000));
        chk("R9 after reset latency", lat, LAT);

        report();
        $finish;
    end

endmodule